// File: doc/BRIEF.md
# DDR3 Termination Power-Down Entry Tracker

This block sits on the controller side of a DDR3 interface. It brings the clock enable (CKE) low for precharge power-down. It also reports, cycle by cycle, how the device's on-die termination is expected to respond at that moment. Before power-down entry starts, termination follows ODT synchronously. While entry is in progress, the response is uncertain and termination may act either way. Once entry has completed, termination responds asynchronously.

A power-down request opens the entry window at once. The window length is derived from the write latency, which is the CAS write latency plus the additive latency, captured when the request is taken. CKE is driven low when that window has run. If a refresh command was issued recently and its refresh cycle time has not yet elapsed, the window stays open past CKE low until the refresh interval expires. When the mode bit says the DLL stays on in power-down, termination is always reported as synchronous. Dropping the request leaves power-down.

Top module: `odt_pd_tracker`

## Requirements
- R1: After reset, CKE is high, the mode output is 2'b00 (synchronous) and busy is low.
- R2: The entry length is tANPD = max(ODTLon, ODTLoff) + 1 cycles. Both termination latencies equal WL - 2, where WL = CWL + AL, and a WL below 2 counts as 0. If the request is sampled at clock edge k, CKE goes low at edge k + tANPD and is high at every edge before that.
- R3: Busy rises on the edge that samples the request. While the window is open and the DLL-on bit is 0, the mode output is 2'b01 (transition).
- R4: With no refresh interval running, the window closes on the edge that drives CKE low. On that edge busy falls and the mode becomes 2'b10 (asynchronous).
- R5: A refresh strobe sampled at edge s loads a down-counter with the programmed tRFC value. If the counter is still nonzero when CKE goes low, CKE stays low, busy stays high and the mode stays 2'b01 until edge s + tRFC. On that edge the mode becomes 2'b10 and busy falls.
- R6: With the DLL-on bit at 1, the mode output is 2'b00 at all times, and CKE timing is unchanged.
- R7: In power-down, the first edge that samples the request low drives CKE high, sets the mode to 2'b00 and leaves busy low. The mode output never shows 2'b11.
- R8: Changes to CWL or AL after the request has been sampled do not alter the CKE timing of the entry in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cwl_i | input | 4 | CAS write latency in cycles |
| al_i | input | 4 | Additive latency in cycles |
| pd_dll_on_i | input | 1 | 1: DLL kept on in power-down (always synchronous) |
| ref_stb_i | input | 1 | One-cycle strobe marking a refresh command |
| pd_req_i | input | 1 | Level request for precharge power-down |
| trfc_i | input | 9 | Refresh cycle time in clock cycles |
| cke_o | output | 1 | Clock enable drive to the device |
| odt_mode_o | output | 2 | 00 synchronous, 01 transition, 10 asynchronous |
| busy_o | output | 1 | Power-down entry in progress |

## Verification
The bench measures the exact edge at which CKE falls for several latency pairs, including a zero write latency that clamps the window to one cycle. A design with an off-by-one in the window counter shows CKE falling a cycle early or late. It runs refresh intervals that end after CKE low, exactly at CKE low, and well before CKE low. A design that ignores the refresh counter, or tests the counter a cycle late, closes the window at the wrong edge. It also changes the latencies in the middle of the window, which a design sampling them live would follow, and it checks that exit happens after a single cycle and that the DLL-on bit keeps the mode synchronous.

// File: rtl/odt_pd_pkg.sv
package odt_pd_pkg;
  typedef enum logic [1:0] {
    ODT_SYNC  = 2'b00,
    ODT_TRANS = 2'b01,
    ODT_ASYNC = 2'b10
  } odt_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WIN  = 2'd1,
    ST_HOLD = 2'd2,
    ST_PD   = 2'd3
  } pd_state_e;
endpackage

// File: rtl/odt_lat_calc.sv
module odt_lat_calc #(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LAT_W-1:0] cwl_i,
  input  logic [LAT_W-1:0] al_i,
  output logic [LAT_W:0]   tanpd_o
);
  localparam int WL_W = LAT_W + 1;

  logic [WL_W-1:0] wl;
  logic [WL_W-1:0] odtl_on;
  logic [WL_W-1:0] odtl_off;
  logic [WL_W-1:0] on_p1;
  logic [WL_W-1:0] off_p1;

  always_comb begin
    wl       = WL_W'(cwl_i) + WL_W'(al_i);
    odtl_on  = (wl >= WL_W'(2)) ? wl - WL_W'(2) : '0;
    odtl_off = (wl >= WL_W'(2)) ? wl - WL_W'(2) : '0;
    on_p1    = odtl_on + WL_W'(1);
    off_p1   = odtl_off + WL_W'(1);
    tanpd_o  = (on_p1 > off_p1) ? on_p1 : off_p1;
  end

  AST_WINDOW_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tanpd_o != '0); // R2
endmodule

// File: rtl/odt_rfc_timer.sv
module odt_rfc_timer #(
  parameter int RFC_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_stb_i,
  input  logic [RFC_W-1:0] trfc_i,
  output logic [RFC_W-1:0] cnt_o,
  output logic [RFC_W-1:0] cnt_nxt_o
);
  logic             cnt_en;
  logic [RFC_W-1:0] cnt_q;

  always_comb begin
    cnt_en    = ref_stb_i || (cnt_q != '0);
    cnt_nxt_o = cnt_q;
    if (ref_stb_i)           cnt_nxt_o = trfc_i;
    else if (cnt_q != '0)    cnt_nxt_o = cnt_q - RFC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt_o;
  end

  assign cnt_o = cnt_q;

  AST_RFC_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !ref_stb_i) |=> (cnt_q == $past(cnt_q) - RFC_W'(1))); // R5
endmodule

// File: rtl/odt_pd_seq.sv
module odt_pd_seq
  import odt_pd_pkg::*;
#(
  parameter int LAT_W = 4,
  parameter int RFC_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_req_i,
  input  logic             pd_dll_on_i,
  input  logic [LAT_W:0]   tanpd_i,
  input  logic [RFC_W-1:0] rfc_cnt_i,
  input  logic [RFC_W-1:0] rfc_nxt_i,
  output logic             cke_o,
  output logic [1:0]       odt_mode_o,
  output logic             busy_o
);
  localparam int WIN_W = LAT_W + 1;

  pd_state_e        state_q, state_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic             win_en;

  always_comb begin
    state_d = state_q;
    win_d   = win_q;
    win_en  = 1'b0;
    case (state_q)
      ST_IDLE: if (pd_req_i) begin
        state_d = ST_WIN;
        win_d   = tanpd_i - WIN_W'(1);
        win_en  = 1'b1;
      end
      ST_WIN: begin
        if (win_q == '0) begin
          state_d = (rfc_nxt_i != '0) ? ST_HOLD : ST_PD;
        end else begin
          win_d  = win_q - WIN_W'(1);
          win_en = 1'b1;
        end
      end
      ST_HOLD: if (rfc_nxt_i == '0) state_d = ST_PD;
      ST_PD:   if (!pd_req_i)       state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      win_q   <= '0;
    end else begin
      state_q <= state_d;
      if (win_en) win_q <= win_d;
    end
  end

  always_comb begin
    cke_o  = (state_q == ST_IDLE) || (state_q == ST_WIN);
    busy_o = (state_q == ST_WIN) || (state_q == ST_HOLD);
    case (state_q)
      ST_WIN, ST_HOLD: odt_mode_o = pd_dll_on_i ? ODT_SYNC : ODT_TRANS;
      ST_PD:           odt_mode_o = pd_dll_on_i ? ODT_SYNC : ODT_ASYNC;
      default:         odt_mode_o = ODT_SYNC;
    endcase
  end

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    odt_mode_o != 2'b11); // R7
  AST_DLL_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    pd_dll_on_i |-> (odt_mode_o == ODT_SYNC)); // R6
  AST_CKE_FALL_AT_WIN_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke_o) |-> ($past(win_q) == '0)); // R2
  AST_HOLD_NEEDS_RFC: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) |-> (rfc_cnt_i != '0)); // R5
  AST_BUSY_DROP_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> !cke_o); // R4
endmodule

// File: rtl/odt_pd_tracker.sv
module odt_pd_tracker
  import odt_pd_pkg::*;
#(
  parameter int LAT_W = 4,
  parameter int RFC_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LAT_W-1:0] cwl_i,
  input  logic [LAT_W-1:0] al_i,
  input  logic             pd_dll_on_i,
  input  logic             ref_stb_i,
  input  logic             pd_req_i,
  input  logic [RFC_W-1:0] trfc_i,
  output logic             cke_o,
  output logic [1:0]       odt_mode_o,
  output logic             busy_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic [LAT_W:0]   tanpd;
  logic [RFC_W-1:0] rfc_cnt;
  logic [RFC_W-1:0] rfc_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  odt_lat_calc #(.LAT_W(LAT_W)) u_lat (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .cwl_i   (cwl_i),
    .al_i    (al_i),
    .tanpd_o (tanpd)
  );

  odt_rfc_timer #(.RFC_W(RFC_W)) u_rfc (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .ref_stb_i (ref_stb_i),
    .trfc_i    (trfc_i),
    .cnt_o     (rfc_cnt),
    .cnt_nxt_o (rfc_nxt)
  );

  odt_pd_seq #(.LAT_W(LAT_W), .RFC_W(RFC_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .pd_req_i    (pd_req_i),
    .pd_dll_on_i (pd_dll_on_i),
    .tanpd_i     (tanpd),
    .rfc_cnt_i   (rfc_cnt),
    .rfc_nxt_i   (rfc_nxt),
    .cke_o       (cke_o),
    .odt_mode_o  (odt_mode_o),
    .busy_o      (busy_o)
  );
endmodule

// File: tb/sim_odt_pd_tracker.sv
module sim_odt_pd_tracker;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] cwl, al;
  logic       dll_on, ref_stb, pd_req;
  logic [8:0] trfc;
  logic       cke, busy;
  logic [1:0] mode;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  odt_pd_tracker u0 (
    .clk(clk), .rst_n(rst_n), .cwl_i(cwl), .al_i(al), .pd_dll_on_i(dll_on),
    .ref_stb_i(ref_stb), .pd_req_i(pd_req), .trfc_i(trfc),
    .cke_o(cke), .odt_mode_o(mode), .busy_o(busy)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_exit();
    @(negedge clk); pd_req = 1'b0;
    step();
    check("R7 cke high after exit", cke, 1);
    check("R7 mode sync after exit", mode, 0);
    check("R7 busy low after exit", busy, 0);
  endtask

  // R2 R3 R4: window length from CWL+AL, then exit
  task automatic t_entry(int c, int a, int exp_len);
    @(negedge clk); cwl = 4'(c); al = 4'(a); pd_req = 1'b1;
    for (int j = 0; j <= exp_len; j++) begin
      step();
      if (j < exp_len) begin
        check("R2 cke high inside window", cke, 1);
        check("R3 busy inside window", busy, 1);
        check("R3 mode transition", mode, 1);
      end else begin
        check("R2 cke low at window end", cke, 0);
        check("R4 busy clears at cke low", busy, 0);
        check("R4 mode async at cke low", mode, 2);
      end
    end
    do_exit();
  endtask

  // R5: refresh strobe together with request, window 4 cycles
  task automatic t_refresh(int rfc);
    int close_at;
    close_at = (rfc > 4) ? rfc : 4;
    @(negedge clk); cwl = 4'd5; al = 4'd0; pd_req = 1'b1; ref_stb = 1'b1; trfc = 9'(rfc);
    @(negedge clk); ref_stb = 1'b0;
    // edge 0 already passed; now after edge 0 (+ half cycle)
    for (int j = 1; j <= close_at; j++) begin
      step();
      if (j >= 4) check("R5 cke low", cke, 0);
      if (j < close_at) begin
        check("R5 mode held transition", mode, 1);
        check("R5 busy held", busy, 1);
      end else begin
        check("R5 mode async at refresh end", mode, 2);
        check("R5 busy clears at refresh end", busy, 0);
      end
    end
    do_exit();
  endtask

  // R6: DLL on keeps mode synchronous, timing unchanged
  task automatic t_dll_on();
    @(negedge clk); dll_on = 1'b1; cwl = 4'd5; al = 4'd0; pd_req = 1'b1;
    for (int j = 0; j <= 4; j++) begin
      step();
      check("R6 mode sync with DLL on", mode, 0);
      check("R6 cke timing", cke, (j < 4) ? 1 : 0);
    end
    check("R6 busy low after entry", busy, 0);
    do_exit();
    @(negedge clk); dll_on = 1'b0;
  endtask

  // R8: latency change mid-window ignored
  task automatic t_latch();
    @(negedge clk); cwl = 4'd5; al = 4'd0; pd_req = 1'b1;
    step();
    @(negedge clk); cwl = 4'd10; al = 4'd5;
    for (int j = 1; j <= 4; j++) begin
      step();
      check("R8 cke timing kept", cke, (j < 4) ? 1 : 0);
    end
    do_exit();
  endtask

  initial begin
    rst_n = 1'b0; cwl = 4'd5; al = 4'd0; dll_on = 1'b0;
    ref_stb = 1'b0; pd_req = 1'b0; trfc = 9'd0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) step();
    check("R1 cke after reset", cke, 1);
    check("R1 mode after reset", mode, 0);
    check("R1 busy after reset", busy, 0);
    t_entry(5, 0, 4);
    t_entry(6, 2, 7);
    t_entry(0, 0, 1);
    t_entry(2, 1, 2);
    t_refresh(10);
    t_refresh(4);
    t_refresh(2);
    t_dll_on();
    t_latch();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule